// File: doc/BRIEF.md
# GPIO Expander Register Bank

This block is the register core of an eight-pin general-purpose I/O expander. A serial front end, such as an I2C or SMBus target, decodes bus transactions into a small register port. That port carries a 2-bit pointer, a write strobe with a data byte, and a read strobe. The read strobe returns a byte on the next clock.

Behind the port sit four byte-wide registers:

- a captured view of the pins,
- an output value,
- a per-pin input inversion mask,
- a per-pin direction mask.

The block turns these registers into an output-enable and an output-value signal for each pad. It also takes in the raw pad levels and passes them through a synchronizer.

Pin 0 is built as an open-drain pin. It can only sink current or float. The other pins drive both levels when they are configured as outputs. Inversion of the read-back level is applied only to pins configured as inputs. The pin view is sampled at the moment a read of pointer 0 is strobed, so a byte that has been returned stays coherent.

Top module: `gpio_xpand_regs`

## Requirements
- R1: While `rst_n` is low, and after it is released, the registers hold their defaults: direction 0xFF, output 0x00, inversion 0xF0, `rd_data` 0x00. While all direction bits are 1, every `pin_oe` bit is 0.
- R2: The pointer codes are: 0 = pin view, 1 = output, 2 = inversion, 3 = direction. A write strobe updates the selected register at the same clock edge. A read strobe loads `rd_data` at its edge with the selected value, and `rd_data` holds that value until the next read strobe.
- R3: A write strobe with pointer 0 leaves the output, inversion and direction registers unchanged.
- R4: A direction bit of 1 sets `pin_oe` of that pin to 0. For pins 1 to 7, a direction bit of 0 sets `pin_oe` to 1, and `pin_out[i]` always equals output bit i.
- R5: A read of pointer 1 returns the stored output byte, whatever the pin levels. Output bits of pins whose direction bit is 1 drive nothing.
- R6: Pin 0 is open-drain. `pin_out[0]` is always 0. `pin_oe[0]` is 1 only when direction bit 0 is 0 and output bit 0 is 0.
- R7: Bit i of a pointer-0 read equals the pin level XOR (inversion bit i AND direction bit i). Pins set as outputs therefore read back their raw level.
- R8: The pin view is taken from a level that has been stable on `pin_in` for at least three clock edges before the read edge. A later change of `pin_in` does not alter `rd_data` until the next read strobe.
- R9: Taking `rst_n` low mid-operation asynchronously clears `pin_oe` and returns all registers to the defaults of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_ptr | input | 2 | Register pointer from the serial front end |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| rd_data | output | 8 | Byte returned by the last read strobe |
| pin_in | input | 8 | Raw pad levels, asynchronous to `clk` |
| pin_oe | output | 8 | Per-pad output enable |
| pin_out | output | 8 | Per-pad output value |

## Verification
The hardest case to reach is the interaction between the inversion mask, the direction mask and the pin level. The read-back level depends on all three at once, and only through a synchronizer and a strobe-timed capture. The bench reaches it by sweeping all 256 pin levels under four direction and inversion pairings, which include mixed masks. It holds each level for three edges before strobing a read. Open-drain behaviour of pin 0 is reached by sweeping every direction byte against two complementary output bytes.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
   typedef enum logic [1:0] {
      PTR_VIEW = 2'd0,
      PTR_OUT  = 2'd1,
      PTR_INV  = 2'd2,
      PTR_DIR  = 2'd3
   } gpx_ptr_e;
endpackage

// File: rtl/gpx_pin_sync.sv
module gpx_pin_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [W-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("gpx_pin_sync: STAGES must be at least 2");
   end

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
         end
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpx_cfg_regs.sv
module gpx_cfg_regs
   import gpx_pkg::*;
#(
   parameter int         W       = 8,
   parameter logic [W-1:0] OUT_RST = '0,
   parameter logic [W-1:0] INV_RST = '0,
   parameter logic [W-1:0] DIR_RST = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  gpx_ptr_e     ptr,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] out_q,
   output logic [W-1:0] inv_q,
   output logic [W-1:0] dir_q
);
   logic hit_out, hit_inv, hit_dir;

   assign hit_out = wr_en && (ptr == PTR_OUT);
   assign hit_inv = wr_en && (ptr == PTR_INV);
   assign hit_dir = wr_en && (ptr == PTR_DIR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       out_q <= OUT_RST;
      else if (hit_out) out_q <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       inv_q <= INV_RST;
      else if (hit_inv) inv_q <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dir_q <= DIR_RST;
      else if (hit_dir) dir_q <= wr_data;
   end
endmodule

// File: rtl/gpx_rd_path.sv
module gpx_rd_path
   import gpx_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd_en,
   input  gpx_ptr_e     ptr,
   input  logic [W-1:0] lvl_sync,
   input  logic [W-1:0] out_q,
   input  logic [W-1:0] inv_q,
   input  logic [W-1:0] dir_q,
   output logic [W-1:0] rd_data
);
   logic [W-1:0] view;
   logic [W-1:0] sel;

   // inversion only acts on pins whose direction bit marks them as inputs
   assign view = lvl_sync ^ (inv_q & dir_q);

   always_comb begin
      unique case (ptr)
         PTR_VIEW: sel = view;
         PTR_OUT:  sel = out_q;
         PTR_INV:  sel = inv_q;
         PTR_DIR:  sel = dir_q;
         default:  sel = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= sel;
   end
endmodule

// File: rtl/gpx_pad_ctrl.sv
module gpx_pad_ctrl #(
   parameter int           W       = 8,
   parameter logic [W-1:0] OD_MASK = '0
) (
   input  logic [W-1:0] out_q,
   input  logic [W-1:0] dir_q,
   output logic [W-1:0] pin_oe,
   output logic [W-1:0] pin_out
);
   for (genvar i = 0; i < W; i++) begin : g_pin
      if (OD_MASK[i]) begin : g_od
         // sink-only pad: drive low for a 0, float for a 1
         assign pin_out[i] = 1'b0;
         assign pin_oe[i]  = ~dir_q[i] & ~out_q[i];
      end else begin : g_pp
         assign pin_out[i] = out_q[i];
         assign pin_oe[i]  = ~dir_q[i];
      end
   end
endmodule

// File: rtl/gpio_xpand_regs.sv
module gpio_xpand_regs #(
   parameter int         PIN_W       = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] OD_MASK     = 8'h01,
   parameter logic [7:0] OUT_RST     = 8'h00,
   parameter logic [7:0] INV_RST     = 8'hF0,
   parameter logic [7:0] DIR_RST     = 8'hFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       reg_ptr,
   input  logic             wr_en,
   input  logic [PIN_W-1:0] wr_data,
   input  logic             rd_en,
   output logic [PIN_W-1:0] rd_data,
   input  logic [PIN_W-1:0] pin_in,
   output logic [PIN_W-1:0] pin_oe,
   output logic [PIN_W-1:0] pin_out
);
   import gpx_pkg::*;

   localparam logic [PIN_W-1:0] OD_M  = OD_MASK[PIN_W-1:0];
   localparam logic [PIN_W-1:0] OUT_D = OUT_RST[PIN_W-1:0];
   localparam logic [PIN_W-1:0] INV_D = INV_RST[PIN_W-1:0];
   localparam logic [PIN_W-1:0] DIR_D = DIR_RST[PIN_W-1:0];

   if (PIN_W < 1 || PIN_W > 8) begin : g_bad_width
      $error("gpio_xpand_regs: PIN_W must lie in 1..8");
   end

   gpx_ptr_e     ptr;
   logic [PIN_W-1:0] lvl_sync, out_q, inv_q, dir_q;

   assign ptr = gpx_ptr_e'(reg_ptr);

   gpx_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(lvl_sync)
   );

   gpx_cfg_regs #(.W(PIN_W), .OUT_RST(OUT_D), .INV_RST(INV_D), .DIR_RST(DIR_D)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data),
      .out_q(out_q), .inv_q(inv_q), .dir_q(dir_q)
   );

   gpx_rd_path #(.W(PIN_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .ptr(ptr), .lvl_sync(lvl_sync),
      .out_q(out_q), .inv_q(inv_q), .dir_q(dir_q), .rd_data(rd_data)
   );

   gpx_pad_ctrl #(.W(PIN_W), .OD_MASK(OD_M)) u_pad (
      .out_q(out_q), .dir_q(dir_q), .pin_oe(pin_oe), .pin_out(pin_out)
   );
endmodule

// File: rtl/gpx_xpand_chk.sv
module gpx_xpand_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [1:0]   reg_ptr,
   input logic         wr_en,
   input logic [W-1:0] wr_data,
   input logic         rd_en,
   input logic [W-1:0] rd_data,
   input logic [W-1:0] pin_oe,
   input logic [W-1:0] out_q,
   input logic [W-1:0] inv_q,
   input logic [W-1:0] dir_q
);
   // R4
   oe_only_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & dir_q) == '0);

   // R6
   od_float_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[0] |-> !out_q[0]);

   // R3
   view_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_ptr == 2'd0) |=> ($stable(out_q) && $stable(inv_q) && $stable(dir_q)));

   // R2
   out_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_ptr == 2'd1) |=> out_q == $past(wr_data));

   // R2
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   // R5
   out_read_flop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && reg_ptr == 2'd1) |=> rd_data == $past(out_q));
endmodule

bind gpio_xpand_regs gpx_xpand_chk #(.W(PIN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_ptr(reg_ptr), .wr_en(wr_en), .wr_data(wr_data),
   .rd_en(rd_en), .rd_data(rd_data), .pin_oe(pin_oe), .out_q(out_q),
   .inv_q(inv_q), .dir_q(dir_q)
);

// File: tb/gpio_xpand_regs_bench.sv
module gpio_xpand_regs_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_ptr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_oe;
   logic [7:0] pin_out;
   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   gpio_xpand_regs u_gpio_xpand_regs (
      .clk(clk), .rst_n(rst_n), .reg_ptr(reg_ptr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
   );

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] p, input logic [7:0] d);
      @(negedge clk);
      reg_ptr = p; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] p, output logic [7:0] v);
      @(negedge clk);
      reg_ptr = p; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   task automatic set_pins(input logic [7:0] lv);
      @(negedge clk);
      pin_in = lv;
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [7:0] exp_oe(input logic [7:0] dir, input logic [7:0] outv);
      logic [7:0] r;
      for (int i = 0; i < 8; i++)
         r[i] = dir[i] ? 1'b0 : ((i == 0) ? ~outv[0] : 1'b1);
      return r;
   endfunction

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      logic [7:0] dirs [4];
      logic [7:0] invs [4];
      dirs = '{8'hFF, 8'h00, 8'hA5, 8'h3C};
      invs = '{8'hF0, 8'hFF, 8'h0F, 8'h99};

      // R1 reset state
      repeat (3) @(negedge clk);
      check8("R1 oe in reset", pin_oe, 8'h00);
      check8("R1 rd_data in reset", rd_data, 8'h00);
      rst_n = 1'b1;
      rd(2'd1, v); check8("R1 out default", v, 8'h00);
      rd(2'd2, v); check8("R1 inv default", v, 8'hF0);
      rd(2'd3, v); check8("R1 dir default", v, 8'hFF);
      rd(2'd0, v); check8("R1 view default", v, 8'hF0);

      // R3 pointer 0 writes ignored
      wr(2'd0, 8'h33);
      rd(2'd1, v); check8("R3 out kept", v, 8'h00);
      rd(2'd2, v); check8("R3 inv kept", v, 8'hF0);
      rd(2'd3, v); check8("R3 dir kept", v, 8'hFF);
      check8("R3 oe kept", pin_oe, 8'h00);

      // R2 write and read back every writable register
      wr(2'd1, 8'hA5); wr(2'd2, 8'h3C); wr(2'd3, 8'h0F);
      rd(2'd1, v); check8("R2 out readback", v, 8'hA5);
      rd(2'd2, v); check8("R2 inv readback", v, 8'h3C);
      rd(2'd3, v); check8("R2 dir readback", v, 8'h0F);
      @(negedge clk); @(negedge clk);
      check8("R2 rd_data held", rd_data, 8'h0F);

      // R4 R6 pad sweep over every direction byte
      for (int d = 0; d < 256; d++) begin
         for (int k = 0; k < 2; k++) begin
            logic [7:0] o;
            o = (k == 0) ? (8'(d) ^ 8'h5A) : ~(8'(d) ^ 8'h5A);
            wr(2'd3, 8'(d)); wr(2'd1, o);
            check8("R4 R6 pin_oe", pin_oe, exp_oe(8'(d), o));
            check8("R4 R6 pin_out", pin_out, {o[7:1], 1'b0});
         end
      end

      // R7 input view sweep with direction/inversion pairings
      for (int c = 0; c < 4; c++) begin
         wr(2'd3, dirs[c]); wr(2'd2, invs[c]);
         for (int p = 0; p < 256; p++) begin
            set_pins(8'(p));
            rd(2'd0, v);
            check8("R7 view", v, 8'(p) ^ (invs[c] & dirs[c]));
         end
      end

      // R5 output read returns the flop, not the pin
      wr(2'd3, 8'h00); wr(2'd1, 8'h96); set_pins(8'h00);
      rd(2'd1, v); check8("R5 out flop read", v, 8'h96);
      wr(2'd3, 8'hFF); wr(2'd1, 8'h5A);
      check8("R5 inputs not driven", pin_oe, 8'h00);
      rd(2'd1, v); check8("R5 out flop read input dir", v, 8'h5A);

      // R8 capture at strobe, held afterwards
      wr(2'd2, 8'h00); set_pins(8'h3C);
      rd(2'd0, v); check8("R8 captured", v, 8'h3C);
      set_pins(8'hC3);
      check8("R8 held after pin change", rd_data, 8'h3C);
      rd(2'd0, v); check8("R8 new capture", v, 8'hC3);

      // R9 asynchronous reset mid-operation
      wr(2'd3, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h11);
      check8("R9 pre-reset oe", pin_oe, 8'hFF);
      @(negedge clk); #3 rst_n = 1'b0; #1;
      check8("R9 oe cleared async", pin_oe, 8'h00);
      check8("R9 rd_data cleared", rd_data, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      rd(2'd1, v); check8("R9 out default", v, 8'h00);
      rd(2'd2, v); check8("R9 inv default", v, 8'hF0);
      rd(2'd3, v); check8("R9 dir default", v, 8'hFF);

      finish_run();
   end
endmodule